// File: doc/BRIEF.md
# TLB Victim Selector with Lockdown Prefix

This block chooses which slot of a fully associative translation buffer is overwritten by the next "write entry" command. It holds a replacement pointer and a lockdown amount `L`. Slots `0` to `L-1` form a protected prefix that is never offered as a victim. A zero lockdown protects nothing. The number of implemented slots is a parameter of up to `2**PTR_W` (64 with the default 6-bit pointer).

After each write-entry strobe, the pointer steps forward by one. When it steps past the last implemented slot, it returns to `L`, so the rotation covers only the unprotected slots. Software can load the pointer directly at any time, so a miss handler can run its own replacement policy.

If the loaded value lies inside the protected prefix or beyond the last implemented slot, the block offers slot `L` instead and resumes rotation from there. If `L` covers every implemented slot, the block reports that no slot can be replaced and stops advancing.

The controller is a three-state machine derived from the pointer and lockdown registers:
- `RS_ROAM`: the pointer holds a legal slot, and that slot is the victim. A write-entry strobe steps it forward (`ROAM->ROAM`). A strobe from the last slot wraps it to `L`.
- `RS_REPAIR`: the pointer holds an illegal value, and the victim is `L`. A write-entry strobe loads the step after `L` (`REPAIR->ROAM`).
- `RS_BLOCKED`: `L` is at least the slot count. The pointer is frozen and shown unchanged. Lowering `L` leaves this state (`BLOCKED->ROAM` or `BLOCKED->REPAIR`).

A software pointer or lockdown write can move the machine between any two states. The machine takes the state that matches the new register values.

Top module: `tlb_victim_sel`

## Requirements
- R1: After reset the pointer and the lockdown amount are both 0: `victim_idx` is 0 and `no_victim` is 0.
- R2: A pointer write (`ptr_wr_en`) loads `ptr_wr_data` into the pointer. When the value is legal (`L <= value < NUM_ENTRIES`), `victim_idx` shows it in the cycle after the write edge.
- R3: While `no_victim` is 0, `victim_idx` always lies in the range `L` to `NUM_ENTRIES-1`.
- R4: If the pointer holds a value below `L`, or at or above `NUM_ENTRIES`, then `victim_idx` is `L`. The next write-entry strobe uses slot `L` and leaves the pointer at the slot after `L`, which is `L` itself if `L = NUM_ENTRIES-1`.
- R5: A write-entry strobe (`entry_wr`) with a legal victim `v < NUM_ENTRIES-1` leaves the pointer at `v+1`.
- R6: A write-entry strobe with victim `NUM_ENTRIES-1` leaves the pointer at `L`, not at 0.
- R7: When `L >= NUM_ENTRIES`, `no_victim` is 1, write-entry strobes leave the pointer unchanged, and `victim_idx` shows the raw pointer.
- R8: A lockdown write (`lock_wr_en`) loads `lock_wr_data` into `L` at the clock edge. `L = 0` protects no slot.
- R9: When a pointer write and a write-entry strobe occur in the same cycle, the software value wins.
- R10: A write-entry strobe in the same cycle as a lockdown write advances using the old `L`. The new `L` applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Software load of the replacement pointer |
| ptr_wr_data | input | PTR_W | Value loaded into the pointer |
| lock_wr_en | input | 1 | Software load of the lockdown amount |
| lock_wr_data | input | PTR_W | New lockdown amount L |
| entry_wr | input | 1 | Write-entry strobe; the slot in `victim_idx` is loaded this cycle |
| victim_idx | output | PTR_W | Slot chosen for the next write-entry |
| no_victim | output | 1 | No unprotected slot exists (`L >= NUM_ENTRIES`) |

## Verification
Every register update lands on the rising edge where the command is sampled. `victim_idx` and `no_victim` are combinational from the registers, so a pointer write, lockdown write or write-entry strobe is visible exactly one edge after it is applied. The bench drives each command just after a falling edge and drops it just after the next rising edge. It then compares the outputs against its arithmetic model at the following falling edge. It sweeps every lockdown value from 0 to two past the slot count against every 6-bit pointer value, then runs a full rotation, so the repair, wrap and blocked paths are all due and checked one cycle after their strobe.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

    // Controller state, derived from the pointer and lockdown registers
    typedef enum logic [1:0] {
        RS_ROAM    = 2'd0,  // pointer is a legal victim
        RS_REPAIR  = 2'd1,  // pointer illegal, victim forced to L
        RS_BLOCKED = 2'd2   // lockdown covers every implemented slot
    } tlbv_state_e;

endpackage

// File: rtl/tlbv_lock_reg.sv
module tlbv_lock_reg #(
    parameter int PTR_W       = 6,
    parameter int NUM_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr_en,
    input  logic [PTR_W-1:0] lock_wr_data,
    output logic [PTR_W-1:0] lock_q,
    output logic [PTR_W-1:0] lock_d,
    output logic             blocked_q,
    output logic             blocked_d
);
    localparam logic [PTR_W:0] CNT = (PTR_W+1)'(NUM_ENTRIES);

    always_comb begin
        lock_d = lock_wr_en ? lock_wr_data : lock_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign blocked_q = ({1'b0, lock_q} >= CNT);
    assign blocked_d = ({1'b0, lock_d} >= CNT);

    // R8: a lockdown write is in force after the edge
    p_lock_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr_en |=> lock_q == $past(lock_wr_data));

    // R8: without a write the amount holds
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr_en |=> lock_q == $past(lock_q));

endmodule

// File: rtl/tlbv_step.sv
module tlbv_step #(
    parameter int PTR_W       = 6,
    parameter int NUM_ENTRIES = 32
) (
    input  logic [PTR_W-1:0] cur_idx,
    input  logic [PTR_W-1:0] lock_amt,
    output logic [PTR_W-1:0] nxt_idx
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

    always_comb begin
        if (cur_idx == LAST) nxt_idx = lock_amt;
        else                 nxt_idx = cur_idx + 1'b1;
    end

endmodule

// File: rtl/tlbv_ctrl.sv
module tlbv_ctrl
    import tlbv_pkg::*;
#(
    parameter int PTR_W       = 6,
    parameter int NUM_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr_en,
    input  logic [PTR_W-1:0] ptr_wr_data,
    input  logic             entry_wr,
    input  logic [PTR_W-1:0] lock_q,
    input  logic [PTR_W-1:0] lock_d,
    input  logic             blocked_d,
    input  logic [PTR_W-1:0] step_idx,
    output logic [PTR_W-1:0] victim_idx,
    output logic             no_victim
);
    localparam logic [PTR_W:0] CNT = (PTR_W+1)'(NUM_ENTRIES);

    tlbv_state_e      state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    function automatic tlbv_state_e classify(input logic [PTR_W-1:0] p,
                                             input logic [PTR_W-1:0] l,
                                             input logic             blk);
        if (blk)                                return RS_BLOCKED;
        else if (p < l || {1'b0, p} >= CNT)     return RS_REPAIR;
        else                                    return RS_ROAM;
    endfunction

    // Next pointer: software load first, then advance if a slot exists
    always_comb begin
        ptr_d = ptr_q;
        if (ptr_wr_en)                            ptr_d = ptr_wr_data;
        else if (entry_wr && state_q != RS_BLOCKED) ptr_d = step_idx;
        state_d = classify(ptr_d, lock_d, blocked_d);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            state_q <= RS_ROAM;
        end else begin
            ptr_q   <= ptr_d;
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RS_ROAM:    begin victim_idx = ptr_q;  no_victim = 1'b0; end
            RS_REPAIR:  begin victim_idx = lock_q; no_victim = 1'b0; end
            RS_BLOCKED: begin victim_idx = ptr_q;  no_victim = 1'b1; end
            default:    begin victim_idx = ptr_q;  no_victim = 1'b1; end
        endcase
    end

    // R3: offered slot is never protected or unimplemented
    p_victim_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !no_victim |-> (victim_idx >= lock_q && {1'b0, victim_idx} < CNT));

    // R2 / R9: software load wins over any advance
    p_sw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr_en |=> ptr_q == $past(ptr_wr_data));

    // R6: leaving the last slot returns to the old lockdown amount
    p_wrap_to_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_wr && !ptr_wr_en && !no_victim &&
         {1'b0, victim_idx} == CNT - 1'b1) |=> ptr_q == $past(lock_q));

    // R7: no advance while every slot is protected
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (no_victim && !ptr_wr_en) |=> ptr_q == $past(ptr_q));

    // R7: blocked flag agrees with the lockdown register
    p_flag_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_victim == ({1'b0, lock_q} >= CNT));

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int PTR_W       = 6,
    parameter int NUM_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr_en,
    input  logic [PTR_W-1:0] ptr_wr_data,
    input  logic             lock_wr_en,
    input  logic [PTR_W-1:0] lock_wr_data,
    input  logic             entry_wr,
    output logic [PTR_W-1:0] victim_idx,
    output logic             no_victim
);
    initial begin
        assert (NUM_ENTRIES >= 1 && NUM_ENTRIES <= (1 << PTR_W))
            else $error("NUM_ENTRIES out of range for PTR_W");
    end

    logic [PTR_W-1:0] lock_q, lock_d, step_idx;
    logic             blocked_q, blocked_d;

    tlbv_lock_reg #(.PTR_W(PTR_W), .NUM_ENTRIES(NUM_ENTRIES)) lock_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_wr_en   (lock_wr_en),
        .lock_wr_data (lock_wr_data),
        .lock_q       (lock_q),
        .lock_d       (lock_d),
        .blocked_q    (blocked_q),
        .blocked_d    (blocked_d)
    );

    tlbv_step #(.PTR_W(PTR_W), .NUM_ENTRIES(NUM_ENTRIES)) step_i (
        .cur_idx  (victim_idx),
        .lock_amt (lock_q),
        .nxt_idx  (step_idx)
    );

    tlbv_ctrl #(.PTR_W(PTR_W), .NUM_ENTRIES(NUM_ENTRIES)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_wr_en   (ptr_wr_en),
        .ptr_wr_data (ptr_wr_data),
        .entry_wr    (entry_wr),
        .lock_q      (lock_q),
        .lock_d      (lock_d),
        .blocked_d   (blocked_d),
        .step_idx    (step_idx),
        .victim_idx  (victim_idx),
        .no_victim   (no_victim)
    );

    // R7: blocked output is in step with the lockdown comparison
    p_top_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_victim == blocked_q);

endmodule

// File: tb/tlb_victim_sel_tb_top.sv
module tlb_victim_sel_tb_top;
    localparam int PW = 6;
    localparam int N  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_wr_en = 1'b0;
    logic [PW-1:0] ptr_wr_data = '0;
    logic          lock_wr_en = 1'b0;
    logic [PW-1:0] lock_wr_data = '0;
    logic          entry_wr = 1'b0;
    logic [PW-1:0] victim_idx;
    logic          no_victim;

    int checks = 0;
    int errors = 0;
    int m_ptr = 0;
    int m_lock = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlb_victim_sel #(.PTR_W(PW), .NUM_ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .lock_wr_en(lock_wr_en), .lock_wr_data(lock_wr_data),
        .entry_wr(entry_wr),
        .victim_idx(victim_idx), .no_victim(no_victim)
    );

    function automatic int exp_victim(int p, int l);
        if (l >= N)             return p;
        if (p < l || p >= N)    return l;
        return p;
    endfunction

    task automatic check(string tag);
        int ev = exp_victim(m_ptr, m_lock);
        int ef = (m_lock >= N) ? 1 : 0;
        checks++;
        if (int'(victim_idx) != ev || int'(no_victim) != ef) begin
            errors++;
            $display("FAIL %s: victim=%0d flag=%0d expected victim=%0d flag=%0d (ptr=%0d L=%0d)",
                     tag, victim_idx, no_victim, ev, ef, m_ptr, m_lock);
        end
    endtask

    // Apply one cycle of commands, update the model, sample at next falling edge
    task automatic step(bit pw, int pd, bit lw, int ld, bit ew);
        int v = exp_victim(m_ptr, m_lock);
        bit blk = (m_lock >= N);
        ptr_wr_en    = pw;
        ptr_wr_data  = PW'(pd);
        lock_wr_en   = lw;
        lock_wr_data = PW'(ld);
        entry_wr     = ew;
        @(posedge clk);
        #1;
        ptr_wr_en = 1'b0; lock_wr_en = 1'b0; entry_wr = 1'b0;
        if (pw)              m_ptr = pd;
        else if (ew && !blk) m_ptr = (v == N-1) ? m_lock : v + 1;
        if (lw)              m_lock = ld;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset");

        // R5/R6 with L=0: rotation through all slots wraps to 0
        for (int k = 0; k < N + 2; k++) begin
            step(0, 0, 0, 0, 1);
            check(k == N-1 ? "R6 wrap L=0" : "R5 advance L=0");
        end

        // Exhaustive sweep over lockdown amount and pointer value
        for (int l = 0; l < N + 3; l++) begin
            for (int p = 0; p < (1 << PW); p++) begin
                step(0, 0, 1, l, 0);
                check("R8 lock load");
                step(1, p, 0, 0, 0);
                if (l >= N)              check("R7 blocked raw pointer");
                else if (p < l || p >= N) check("R4 repair to L");
                else                     check("R2 pointer load");
                for (int k = 0; k < N + 1; k++) begin
                    step(0, 0, 0, 0, 1);
                    if (l >= N)                check("R7 frozen");
                    else if (m_ptr == l)       check("R6 wrap to L");
                    else                       check("R5 advance");
                    if (l < N) check("R3 legal victim");
                end
            end
        end

        // R9: pointer write with simultaneous entry write
        step(0, 0, 1, 2, 0);
        step(1, 5, 0, 0, 0);
        step(1, 9, 0, 0, 1);
        check("R9 software wins");

        // R10: lock write with simultaneous entry write at last slot
        step(1, N-1, 0, 0, 0);
        step(0, 0, 1, 4, 1);
        check("R10 wrap uses old L");
        if (m_ptr != 2) begin
            errors++;
            $display("FAIL R10 model: ptr=%0d expected 2", m_ptr);
        end

        // R8: L=0 protects nothing, slot 0 can be offered
        step(0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        check("R8 zero lockdown");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule